// File: doc/BRIEF.md
# Motion Interrupt Generator

This block turns a stream of signed three-axis acceleration samples into one interrupt. Each sample comes with a one-cycle valid strobe. For each axis, the block compares the magnitude of the sample with a programmed threshold. This gives a "high" and a "low" event per axis. The enabled events are then merged by one of four rules:

- any-of (OR)
- all-of (AND)
- six-direction position
- six-direction movement

A merged condition must hold for a programmed number of consecutive samples before the block accepts it.

The accepted result and the per-axis event flags appear in a source byte. Optionally, the source byte is latched until software reads it. The interrupt pin has selectable polarity, a choice of push-pull or open-drain drive, and a four-way source selector. Software programs the block through a small write port. It reads the source byte through a read strobe, and the source byte is always visible on an output.

Top module: `motion_irq`

## Requirements
- R1: After reset every register is zero: `src` reads 0x00, and the pin is push-pull and active-high, so `pad_oe`=1 and `pad_o`=0.
- R2: The scaled magnitude of an axis is |sample| >> (DW-8), an 8-bit value. High means scaled > threshold and low means scaled < threshold; an equal value gives neither event. `src` bit 7 reads 0 and bit 6 is the interrupt-active flag. Bits 5..0 are the enabled events {Z high, Z low, Y high, Y low, X high, X low}, refreshed on each accepted sample update.
- R3: Mode 00 (config bits [7:6]): the condition is true when any enabled event is present.
- R4: Mode 10: the condition is true when at least one event is enabled and every enabled event is present.
- R5: Mode 11 (position): the condition is true while exactly one enabled event is present.
- R6: Mode 01 (movement): the condition is true when exactly one enabled event is present and it differs from the direction stored at the last recognition. Each recognition stores its pattern as the new direction; the stored direction resets to none.
- R7: With duration D, a condition is recognised on its (D+1)-th consecutive sample, so D=0 means immediate recognition. Any sample without the condition restarts the count.
- R8: Without latching, the interrupt flag follows recognition on every sample and holds between samples. The read strobe has no effect.
- R9: With latching (control bit 0), a set interrupt flag freezes `src` until a read strobe. The read clears the flag, and the next sample refreshes the event bits.
- R10: When a read strobe and a sample come in the same cycle with a latched flag set, the sample is evaluated as though the latch had already been released.
- R11: Control bit 1 makes the pin active-low. Control bit 2 selects open-drain, in which `pad_o`=0 and `pad_oe` is set only while the pin level is low. Otherwise `pad_oe`=1 and `pad_o` is the level.
- R12: Control bits [4:3] select the pin source: 00 own flag, 01 own flag OR `peer_irq`, 10 `data_ready`, 11 `boot_busy`.
- R13: Writes go to address 0 (config: bit 7 AND-select, bit 6 six-direction, bits 5..0 enables in the R2 order), address 1 (threshold, 7 bits), address 2 (duration, 7 bits) and address 3 (control). A write takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | One-cycle strobe for a new sample |
| ax | input | DW | Signed X sample |
| ay | input | DW | Signed Y sample |
| az | input | DW | Signed Z sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| rd_src | input | 1 | Source-byte read strobe |
| peer_irq | input | 1 | Interrupt of a neighbouring generator |
| data_ready | input | 1 | New-data indication |
| boot_busy | input | 1 | Boot-in-progress indication |
| src | output | 8 | Source byte |
| pad_o | output | 1 | Pin output value |
| pad_oe | output | 1 | Pin output enable |

## Verification
A software read and a new sample can arrive in the same clock while the latch is holding a set flag. The release and the fresh evaluation then compete for the interrupt flag. The bench provokes this in two ways: by asserting the read strobe together with the sample valid strobe, once with a sample that satisfies the condition and once with one that does not. The outcome is judged by the reference model, which applies the release before evaluating the sample. The flag must therefore equal that sample's recognition result, and the event bits must equal that sample's events.

// File: rtl/motion_irq.sv
module motion_irq #(
  parameter int DW = 12,
  parameter int TW = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_valid,
  input  logic signed [DW-1:0] ax,
  input  logic signed [DW-1:0] ay,
  input  logic signed [DW-1:0] az,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic                 rd_src,
  input  logic                 peer_irq,
  input  logic                 data_ready,
  input  logic                 boot_busy,
  output logic [7:0]           src,
  output logic                 pad_o,
  output logic                 pad_oe
);
  localparam int SW = TW + 1;
  localparam int SH = DW - SW;

  logic [7:0]    cfg_r;
  logic [TW-1:0] thr_r, dur_r, cnt_r;
  logic [4:0]    ctl_r;
  logic [5:0]    flags_r, ref_r;
  logic          ia_r;

  logic [DW-1:0] axis_v [3];
  logic [5:0]    ev, pat;
  logic          cond, hit, latch, hold;

  assign axis_v[0] = ax;
  assign axis_v[1] = ay;
  assign axis_v[2] = az;

  for (genvar i = 0; i < 3; i++) begin : g_axis
    logic [DW-1:0] mag;
    logic [SW-1:0] sc;
    logic          unused_lo;
    assign mag         = axis_v[i][DW-1] ? (~axis_v[i] + 1'b1) : axis_v[i];
    assign sc          = mag[DW-1:SH];
    assign unused_lo   = ^mag[SH-1:0];
    assign ev[2*i+1]   = sc > {1'b0, thr_r};
    assign ev[2*i]     = sc < {1'b0, thr_r};
  end

  assign pat = ev & cfg_r[5:0];

  always_comb begin
    unique case (cfg_r[7:6])
      2'b00:   cond = |pat;
      2'b10:   cond = (cfg_r[5:0] != 6'd0) && ((ev | ~cfg_r[5:0]) == 6'h3f);
      2'b11:   cond = $onehot(pat);
      default: cond = $onehot(pat) && (pat != ref_r);
    endcase
  end

  assign hit   = cond && (cnt_r >= dur_r);
  assign latch = ctl_r[0];
  assign hold  = latch && ia_r && !rd_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_r <= '0; thr_r <= '0; dur_r <= '0; ctl_r <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: cfg_r <= wr_data;
        2'd1: thr_r <= wr_data[TW-1:0];
        2'd2: dur_r <= wr_data[TW-1:0];
        default: ctl_r <= wr_data[4:0];
      endcase
    end
  end

  logic unused_wr;
  assign unused_wr = ^wr_data[7:TW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0; ref_r <= '0; ia_r <= 1'b0; flags_r <= '0;
    end else begin
      if (sample_valid) begin
        if (!cond)              cnt_r <= '0;
        else if (cnt_r < dur_r) cnt_r <= cnt_r + 1'b1;
        if (hit) ref_r <= pat;
      end
      if (sample_valid && !hold) begin
        ia_r    <= hit;
        flags_r <= pat;
      end else if (latch && rd_src) begin
        ia_r <= 1'b0;
      end
    end
  end

  assign src = {1'b0, ia_r, flags_r};

  logic lvl, act;
  always_comb begin
    unique case (ctl_r[4:3])
      2'b00:   lvl = ia_r;
      2'b01:   lvl = ia_r | peer_irq;
      2'b10:   lvl = data_ready;
      default: lvl = boot_busy;
    endcase
  end

  assign act    = lvl ^ ctl_r[1];
  assign pad_o  = ctl_r[2] ? 1'b0 : act;
  assign pad_oe = ctl_r[2] ? !act : 1'b1;
endmodule

// File: rtl/motion_irq_chk.sv
module motion_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_valid,
  input logic       rd_src,
  input logic       wr_en,
  input logic [7:0] src,
  input logic [1:0] mode,
  input logic       latch
);
  AST_IA_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    src[6] |-> (src[5:0] != 6'd0)); // R3
  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_valid && !rd_src) |=> $stable(src)); // R8
  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && src[6] && !rd_src && !wr_en) |=> src[6]); // R9
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && rd_src && !sample_valid) |=> !src[6]); // R9
  AST_POS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_valid && mode == 2'b11 && !(latch && src[6] && !rd_src))
    |=> (!src[6] || $onehot(src[5:0]))); // R5
endmodule

bind motion_irq motion_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .rd_src(rd_src),
  .wr_en(wr_en), .src(src), .mode(cfg_r[7:6]), .latch(ctl_r[0])
);

// File: tb/motion_irq_test.sv
`timescale 1ns/1ps
module motion_irq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 12;

  logic clk = 0, rst_n = 0;
  logic sample_valid = 0, wr_en = 0, rd_src = 0;
  logic signed [DW-1:0] ax = 0, ay = 0, az = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic peer_irq = 0, data_ready = 0, boot_busy = 0;
  logic [7:0] src;
  logic pad_o, pad_oe;

  int checks = 0, errors = 0;
  string phase = "R1 reset";

  int m_cfg, m_thr, m_dur, m_ctl, m_ia, m_flags, m_cnt, m_ref;

  always #(CLK_PERIOD/2) clk = ~clk;

  motion_irq #(.DW(DW), .TW(7)) uut (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .ax(ax), .ay(ay), .az(az),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_src(rd_src),
    .peer_irq(peer_irq), .data_ready(data_ready), .boot_busy(boot_busy),
    .src(src), .pad_o(pad_o), .pad_oe(pad_oe));

  function automatic int bits_set(int v);
    int n = 0;
    for (int k = 0; k < 6; k++) if (v[k]) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 0; m_thr = 0; m_dur = 0; m_ctl = 0;
      m_ia = 0; m_flags = 0; m_cnt = 0; m_ref = 0;
    end else begin
      if (sample_valid) begin
        int vals[3];
        int ev, p, en, cond, hitv, latched;
        vals[0] = ax; vals[1] = ay; vals[2] = az;
        ev = 0;
        for (int a = 0; a < 3; a++) begin
          int mag;
          mag = (vals[a] < 0 ? -vals[a] : vals[a]) / (1 << (DW - 8));
          if (mag > m_thr) ev |= 1 << (2*a + 1);
          if (mag < m_thr) ev |= 1 << (2*a);
        end
        en = m_cfg & 63;
        p = ev & en;
        case (m_cfg >> 6)
          0: cond = (p != 0);
          2: cond = (en != 0) && ((ev & en) == en);
          3: cond = (bits_set(p) == 1);
          default: cond = (bits_set(p) == 1) && (p != m_ref);
        endcase
        hitv = cond && (m_cnt >= m_dur);
        if (!cond) m_cnt = 0; else if (m_cnt < m_dur) m_cnt++;
        if (hitv) m_ref = p;
        latched = m_ctl & 1;
        if (!(latched && m_ia && !rd_src)) begin m_ia = hitv; m_flags = p; end
      end else if ((m_ctl & 1) && rd_src) m_ia = 0;
      if (wr_en) case (wr_addr)
        0: m_cfg = wr_data;
        1: m_thr = wr_data & 127;
        2: m_dur = wr_data & 127;
        default: m_ctl = wr_data & 31;
      endcase
    end
  end

  always @(negedge clk) begin
    int lvl, act, e_src, e_o, e_oe;
    e_src = (m_ia << 6) | m_flags;
    case ((m_ctl >> 3) & 3)
      0: lvl = m_ia;
      1: lvl = m_ia | peer_irq;
      2: lvl = data_ready;
      default: lvl = boot_busy;
    endcase
    act = lvl ^ ((m_ctl >> 1) & 1);
    e_o = (m_ctl & 4) ? 0 : act;
    e_oe = (m_ctl & 4) ? !act : 1;
    checks++;
    if (src !== e_src[7:0] || pad_o !== e_o[0] || pad_oe !== e_oe[0]) begin
      errors++;
      $display("FAIL %s: src=%h pad_o=%b pad_oe=%b expected src=%h pad_o=%0d pad_oe=%0d",
               phase, src, pad_o, pad_oe, e_src[7:0], e_o, e_oe);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = a[1:0]; wr_data = d[7:0]; step(); wr_en = 0;
  endtask
  task automatic samp(input int x, input int y, input int z, input bit rd = 0);
    sample_valid = 1; rd_src = rd; ax = x[DW-1:0]; ay = y[DW-1:0]; az = z[DW-1:0];
    step(); sample_valid = 0; rd_src = 0; step();
  endtask
  task automatic rd(); rd_src = 1; step(); rd_src = 0; step(); endtask
  task automatic hand(input string tag, input logic [7:0] exp);
    @(negedge clk); checks++;
    if (src !== exp) begin
      errors++; $display("FAIL %s: src=%h expected %h", tag, src, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1; step();
    hand("R1 reset source", 8'h00);
    phase = "R13 R3 OR mode";
    wr(0, 8'h3f); wr(1, 16);
    samp(-300, 256, 100);
    hand("R2 magnitude compare", 8'h52);
    samp(256, 256, 256);
    hand("R2 equal gives no event", 8'h00);
    samp(20, 300, -2048);
    phase = "R4 AND mode";
    wr(0, 8'h95);
    samp(10, -20, 30);
    hand("R4 all low", 8'h55);
    samp(10, -20, 900);
    samp(0, 0, 0);
    wr(0, 8'h80); samp(0, 0, 0);
    hand("R4 no enables", 8'h00);
    phase = "R5 position";
    wr(0, 8'hea);
    samp(0, 0, 1000);
    hand("R5 single direction", 8'h60);
    samp(900, 0, 1000); samp(0, -700, 0);
    phase = "R6 movement";
    wr(0, 8'h6a);
    samp(0, 0, 1000);
    hand("R6 new direction", 8'h60);
    samp(0, 0, 1000);
    hand("R6 same direction drops", 8'h20);
    samp(600, 0, 0); samp(600, 0, 0); samp(0, 0, 1000);
    phase = "R7 duration";
    wr(0, 8'h02); wr(2, 3);
    for (int k = 0; k < 3; k++) samp(400, 0, 0);
    hand("R7 not yet", 8'h02);
    samp(400, 0, 0);
    hand("R7 fourth sample", 8'h42);
    samp(0, 0, 0); samp(400, 0, 0); samp(400, 0, 0);
    wr(2, 0); samp(400, 0, 0);
    phase = "R8 unlatched";
    samp(0, 0, 0); rd(); samp(400, 0, 0); rd();
    hand("R8 read ignored", 8'h42);
    phase = "R9 latch";
    wr(3, 1);
    samp(400, 0, 0); samp(0, 0, 0); samp(0, 0, 0);
    hand("R9 held", 8'h42);
    rd();
    hand("R9 read clears", 8'h02);
    samp(0, 0, 0);
    phase = "R10 read with sample";
    samp(400, 0, 0);
    samp(0, 0, 0, 1);
    hand("R10 release then miss", 8'h00);
    samp(400, 0, 0); samp(500, 0, 0, 1);
    hand("R10 release then hit", 8'h42);
    phase = "R11 polarity and drive";
    wr(3, 8'h03); step(); wr(3, 8'h07); step(); wr(3, 8'h05); step();
    rd(); step(); wr(3, 8'h02); step();
    phase = "R12 source select";
    wr(3, 8'h08); peer_irq = 1; step(); peer_irq = 0; step();
    wr(3, 8'h10); data_ready = 1; step(); data_ready = 0; step();
    wr(3, 8'h18); boot_busy = 1; step(); boot_busy = 0; step();
    wr(3, 8'h1c); boot_busy = 1; step(); step();
    finish_run();
  end
endmodule